// File: doc/BRIEF.md
# Masked block and flash fill engine for a video memory random-access port

This block is the write side of the random-access port of a video frame memory. It accepts one decoded memory cycle per clock. The cycle can be a plain word write, a masked word write, a four-column block fill, a whole-row flash fill, a word read, or an access to the fill colour register. The cycle carries a row, a column, four data bits and, when masking is requested, four mask bits that were sampled when the cycle began. The block holds the colour register that supplies fill data. It also drives a behavioural row-by-column array of four-bit words.

A block fill affects the four-column group that contains the column address. The two low column bits are ignored, so the group starts at a multiple of four. Each data bit acts as an enable for one column of the group. Data bit j selects the column at the group base plus j. A flash fill rewrites every column of the addressed row in the same clock. Both fill types write the colour register value through the bit mask. Any bit that the mask excludes keeps its old value.

Top module: `vram_fill_engine`

## Requirements
- R1: With op_i = 1 (word write) and wmask_en_i = 0, the word at (row_i, col_i) becomes din_i, and wmask_i has no effect.
- R2: With op_i = 1 and wmask_en_i = 1, each bit b for which wmask_i[b] = 1 takes din_i[b], and each bit for which wmask_i[b] = 0 keeps its stored value.
- R3: With op_i = 2 (block fill), the group base is col_i with its two low bits cleared. Column base+j of row row_i is written if and only if din_i[j] = 1. Every other word in the array is unchanged.
- R4: Each word written by a block fill takes the colour register value. When wmask_en_i = 1, the mask of R2 applies to it. When wmask_en_i = 0, all four bits are written.
- R5: With op_i = 3 (flash fill), every column of row row_i takes the colour register value, with the mask rule of R4 applied. Other rows are unchanged.
- R6: With op_i = 5 (colour write), the colour register loads din_i. A fill cycle in the next clock uses the new value.
- R7: With op_i = 6 (colour read), rd_data_o shows the colour register one clock later, and rd_valid_o is 1 in that clock.
- R8: With op_i = 4 (word read), rd_data_o shows the word at (row_i, col_i) one clock later, with rd_valid_o = 1. After any other op, including NOP (0) and 7, rd_valid_o is 0 one clock later.
- R9: Reset (rst_n low) clears the array, the colour register, rd_data_o and rd_valid_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 3 | Cycle type: 0 NOP, 1 word write, 2 block fill, 3 flash fill, 4 word read, 5 colour write, 6 colour read, 7 NOP |
| row_i | input | ROW_AW | Row address |
| col_i | input | COL_AW | Column address |
| din_i | input | 4 | Write data, colour load data, or per-column enables for a block fill |
| wmask_en_i | input | 1 | Masked cycle (write enable low at cycle start) |
| wmask_i | input | 4 | Per-bit write mask sampled at cycle start, 1 = write |
| rd_data_o | output | 4 | Read data for word reads and colour reads |
| rd_valid_o | output | 1 | rd_data_o holds the result of the previous read cycle |

## Verification
In a block fill, the per-column enables taken from the data bits and the per-bit mask both act on the same words in the same clock. An error in either one, or in how the two combine, shows up only for particular pairs of values. The bench therefore runs every enable pattern against every mask value, alternates masked and unmasked cycles, and uses unaligned column addresses and a changing colour. After each fill it reads back the whole affected row and compares it with a shadow array. For flash fills, the bench also reads back the neighbouring row to confirm that no write spilled into it.

// File: rtl/vfe_pkg.sv
package vfe_pkg;
  localparam int VFE_DW = 4;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WRITE  = 3'd1,
    OP_BLOCK  = 3'd2,
    OP_FLASH  = 3'd3,
    OP_READ   = 3'd4,
    OP_CLR_WR = 3'd5,
    OP_CLR_RD = 3'd6,
    OP_RSVD   = 3'd7
  } vfe_op_e;

  typedef logic [VFE_DW-1:0] word_t;

  // Bits selected by wmask take nw, the rest keep old.
  function automatic word_t merge_bits(word_t old, word_t nw, word_t wmask);
    return (old & ~wmask) | (nw & wmask);
  endfunction

  // An unmasked cycle writes every bit.
  function automatic word_t eff_mask(logic masked, word_t bits);
    return masked ? bits : {VFE_DW{1'b1}};
  endfunction
endpackage

// File: rtl/vfe_color_reg.sv
module vfe_color_reg
  import vfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t din,
  output word_t color_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) color_q <= '0;
    else if (load) color_q <= din;
  end
endmodule

// File: rtl/vfe_wr_ctl.sv
module vfe_wr_ctl
  import vfe_pkg::*;
#(
  parameter int COL_AW = 6,
  localparam int COLS = 1 << COL_AW
) (
  input  vfe_op_e                        op,
  input  logic [COL_AW-1:0]              col,
  input  word_t                          din,
  input  logic                           masked,
  input  word_t                          mask_bits,
  input  word_t                          color,
  input  logic [COLS-1:0][VFE_DW-1:0]    row_q,
  output logic [COLS-1:0]                col_we,
  output logic [COLS-1:0][VFE_DW-1:0]    col_wd
);
  word_t m_eff;
  word_t fill;
  assign m_eff = eff_mask(masked, mask_bits);
  assign fill  = (op == OP_WRITE) ? din : color;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [COL_AW-1:0] CIDX = COL_AW'(c);
    logic hit_word, hit_group;
    assign hit_word  = (col == CIDX);
    assign hit_group = (col[COL_AW-1:2] == CIDX[COL_AW-1:2]);
    always_comb begin
      unique case (op)
        OP_WRITE: col_we[c] = hit_word;
        OP_BLOCK: col_we[c] = hit_group & din[c % 4];
        OP_FLASH: col_we[c] = 1'b1;
        default:  col_we[c] = 1'b0;
      endcase
    end
    assign col_wd[c] = merge_bits(row_q[c], fill, m_eff);
  end
endmodule

// File: rtl/vfe_array.sv
module vfe_array
  import vfe_pkg::*;
#(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 6,
  localparam int ROWS = 1 << ROW_AW,
  localparam int COLS = 1 << COL_AW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ROW_AW-1:0]           row,
  input  logic [COLS-1:0]             col_we,
  input  logic [COLS-1:0][VFE_DW-1:0] col_wd,
  output logic [COLS-1:0][VFE_DW-1:0] row_q
);
  logic [COLS-1:0][VFE_DW-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      for (int c = 0; c < COLS; c++)
        if (col_we[c]) mem[row][c] <= col_wd[c];
    end
  end

  assign row_q = mem[row];
endmodule

// File: rtl/vram_fill_engine.sv
module vram_fill_engine
  import vfe_pkg::*;
#(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 6,
  localparam int COLS = 1 << COL_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ROW_AW-1:0] row_i,
  input  logic [COL_AW-1:0] col_i,
  input  logic [3:0]        din_i,
  input  logic              wmask_en_i,
  input  logic [3:0]        wmask_i,
  output logic [3:0]        rd_data_o,
  output logic              rd_valid_o
);
  vfe_op_e                     op;
  word_t                       color_q;
  logic [COLS-1:0]             col_we;
  logic [COLS-1:0][VFE_DW-1:0] col_wd;
  logic [COLS-1:0][VFE_DW-1:0] row_q;

  // Named events for the checker.
  logic ev_clr_wr, ev_clr_rd, ev_read;
  assign op        = vfe_op_e'(op_i);
  assign ev_clr_wr = (op == OP_CLR_WR);
  assign ev_clr_rd = (op == OP_CLR_RD);
  assign ev_read   = (op == OP_READ);

  vfe_color_reg u_color (
    .clk(clk), .rst_n(rst_n), .load(ev_clr_wr), .din(din_i), .color_q(color_q)
  );

  vfe_wr_ctl #(.COL_AW(COL_AW)) u_ctl (
    .op(op), .col(col_i), .din(din_i), .masked(wmask_en_i),
    .mask_bits(wmask_i), .color(color_q), .row_q(row_q),
    .col_we(col_we), .col_wd(col_wd)
  );

  vfe_array #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .row(row_i), .col_we(col_we),
    .col_wd(col_wd), .row_q(row_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= ev_read | ev_clr_rd;
      if (ev_read)        rd_data_o <= row_q[col_i];
      else if (ev_clr_rd) rd_data_o <= color_q;
    end
  end
endmodule

// File: rtl/vfe_checker.sv
module vfe_checker
  import vfe_pkg::*;
#(
  parameter int COL_AW = 6,
  localparam int COLS = 1 << COL_AW
) (
  input logic              clk,
  input logic              rst_n,
  input vfe_op_e           op,
  input logic [COL_AW-1:0] col_i,
  input logic [3:0]        din_i,
  input logic [COLS-1:0]   col_we,
  input word_t             color_q,
  input logic [3:0]        rd_data_o,
  input logic              rd_valid_o
);
  logic [COLS-1:0] blk_window;
  assign blk_window = COLS'(din_i) << {col_i[COL_AW-1:2], 2'b00};

  p_word_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |-> ($countones(col_we) == 1));

  p_block_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BLOCK) |-> (col_we == blk_window));

  p_flash_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLASH) |-> (&col_we));

  p_color_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR_WR) |=> (color_q == $past(din_i)));

  p_color_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR_RD) |=> (rd_valid_o && rd_data_o == $past(color_q)));

  p_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ && op != OP_CLR_RD) |=> !rd_valid_o);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ || op == OP_NOP || op == OP_RSVD) |-> (col_we == '0));
endmodule

bind vram_fill_engine vfe_checker #(.COL_AW(COL_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .col_i(col_i), .din_i(din_i),
  .col_we(col_we), .color_q(color_q), .rd_data_o(rd_data_o),
  .rd_valid_o(rd_valid_o)
);

// File: tb/test_vram_fill_engine.sv
module test_vram_fill_engine;
  localparam int RAW = 4, CAW = 6, NR = 16, NC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [RAW-1:0] row = '0;
  logic [CAW-1:0] col = '0;
  logic [3:0] din = '0, mbits = '0;
  logic men = 1'b0;
  logic [3:0] rd_data;
  logic rd_valid;

  int checks = 0, errors = 0;
  logic [3:0] sh [NR][NC];
  logic [3:0] shc;

  always #2.5 clk = ~clk;

  vram_fill_engine #(.ROW_AW(RAW), .COL_AW(CAW)) i_vram_fill_engine (
    .clk(clk), .rst_n(rst_n), .op_i(op), .row_i(row), .col_i(col),
    .din_i(din), .wmask_en_i(men), .wmask_i(mbits),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  function automatic logic [3:0] blend(logic [3:0] old, logic [3:0] nw,
                                       logic me, logic [3:0] mb);
    logic [3:0] res = old;
    for (int b = 0; b < 4; b++) if (!me || mb[b]) res[b] = nw[b];
    return res;
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] o, int r, int c, logic [3:0] d,
                       logic me, logic [3:0] mb);
    op = o; row = RAW'(r); col = CAW'(c); din = d; men = me; mbits = mb;
    @(negedge clk);
  endtask

  task automatic rd_chk(int r, int c, string tag);
    issue(3'd4, r, c, 4'h0, 1'b0, 4'h0);
    chk(tag, rd_data, sh[r][c]);
    chk({tag, " valid"}, {3'b0, rd_valid}, 4'h1);
  endtask

  task automatic row_chk(int r, string tag);
    for (int c = 0; c < NC; c++) rd_chk(r, c, tag);
  endtask

  task automatic set_color(logic [3:0] v);
    issue(3'd5, 0, 0, v, 1'b0, 4'h0);
    shc = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) sh[r][c] = 4'h0;
    shc = 4'h0;
    repeat (3) @(negedge clk);
    chk("R9 reset rd_data", rd_data, 4'h0);
    chk("R9 reset rd_valid", {3'b0, rd_valid}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(5, 9, "R9 array cleared");
    rd_chk(15, 63, "R9 array cleared");
    issue(3'd6, 0, 0, 4'h0, 1'b0, 4'h0);
    chk("R9 colour cleared", rd_data, 4'h0);

    // R1: unmasked word writes, mask bits present but ignored.
    for (int c = 0; c < NC; c++) begin
      logic [3:0] v = 4'((c * 7 + 3) & 15);
      issue(3'd1, 0, c, v, 1'b0, 4'((c * 3) & 15));
      sh[0][c] = v;
    end
    row_chk(0, "R1 word write");

    // R2: masked word writes over all mask values.
    for (int m = 0; m < 16; m++) begin
      logic [3:0] v = ~sh[0][m];
      issue(3'd1, 0, m, v, 1'b1, 4'(m));
      sh[0][m] = blend(sh[0][m], v, 1'b1, 4'(m));
      rd_chk(0, m, "R2 masked write");
    end

    // R6/R7: colour register load and read-back, R8 valid drops after.
    for (int v = 0; v < 16; v++) begin
      set_color(4'(v));
      issue(3'd6, 0, 0, 4'h0, 1'b0, 4'h0);
      chk("R7 colour read", rd_data, 4'(v));
      chk("R7 colour valid", {3'b0, rd_valid}, 4'h1);
      issue(3'd0, 0, 0, 4'h0, 1'b0, 4'h0);
      chk("R8 valid low after NOP", {3'b0, rd_valid}, 4'h0);
      issue(3'd7, 0, 0, 4'hF, 1'b0, 4'h0);
      chk("R8 valid low after op 7", {3'b0, rd_valid}, 4'h0);
    end
    rd_chk(0, 3, "R8 op 7 left array alone");

    // R3/R4/R6: every enable pattern against every mask, fresh colour each time.
    for (int e = 0; e < 16; e++) begin
      for (int m = 0; m < 16; m++) begin
        int r = (e + m) & 15;
        int c = (e * 4 + m * 5) & 63;
        logic me = ((e + m) & 1) == 0;
        set_color(4'((e * 5 + m + 1) & 15));
        issue(3'd2, r, c, 4'(e), me, 4'(m));
        for (int j = 0; j < 4; j++)
          if (e[j]) sh[r][(c / 4) * 4 + j] = blend(sh[r][(c / 4) * 4 + j], shc, me, 4'(m));
        row_chk(r, "R3 R4 block fill");
      end
    end

    // R5: flash fill, masked and unmasked, with the next row checked too.
    for (int m = 0; m < 16; m++) begin
      for (int me = 0; me < 2; me++) begin
        set_color(4'((m * 3 + me + 6) & 15));
        issue(3'd3, m, (m * 11) & 63, 4'h0, me[0], 4'(m));
        for (int c = 0; c < NC; c++) sh[m][c] = blend(sh[m][c], shc, me[0], 4'(m));
        row_chk(m, "R5 flash fill");
        row_chk((m + 1) & 15, "R5 neighbour row");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule